// File: doc/BRIEF.md
# Arithmetic Unit with Protected Flag Register

This block is the datapath core of a small 8-bit processor. It combines a working-register value with a second operand, which may come from a file register or from an immediate field, and returns the result in the same cycle. The supported operations are add, subtract, the three bitwise logical operations, increment and decrement, rotate through carry, nibble swap, single-bit clear and set, clear, and a plain move. The block owns the flag register. That register holds zero, digit carry and carry, two reset-cause bits (time-out and power-down) and a bank-select bit.

The surrounding decoder presents one operation per cycle with `valid_i` and states whether the result is also written into the flag register. The flag register then follows a protection rule. Whenever an operation produces its own zero, digit carry or carry value, that value wins over the written data for that bit. The two reset-cause bits are never written by operations. They are changed only through a separate port that reset logic drives.

Top module: `ulg_alu_top`

## Requirements
- R1: While `rst_n` is low and after reset, `status_o` reads 8'h18: time-out (bit 4) and power-down (bit 3) are 1, and bank select (bit 5), zero (bit 2), digit carry (bit 1) and carry (bit 0) are 0.
- R2: Op code 4'h1 (add) returns f+w modulo 256. Carry (bit 0) takes the carry out of bit 7, digit carry (bit 1) takes the carry out of bit 3, and zero (bit 2) is set when the result is 0.
- R3: Op code 4'h2 (subtract) returns f-w modulo 256 by adding the two's complement of w. Carry is 1 when there is no borrow (f >= w), digit carry is 1 when f[3:0] >= w[3:0], and zero is set on a zero result.
- R4: Op codes 4'h3 (and), 4'h4 (or), 4'h5 (xor), 4'h6 (f+1) and 4'h7 (f-1) update only the zero flag. Digit carry and carry keep their values.
- R5: Op code 4'h8 rotates f left through carry ({f[6:0],C}, with C taking f[7]). Op code 4'h9 rotates f right through carry ({C,f[7:1]}, with C taking f[0]). Only carry is updated.
- R6: Op codes 4'h0 (move f), 4'hA (swap the nibbles of f), 4'hC (clear bit `bit_i` of f), 4'hD (set bit `bit_i` of f), 4'hE and 4'hF (both act as move) leave zero, digit carry and carry unchanged.
- R7: Op code 4'hB (clear) returns 0 and sets zero. Digit carry and carry keep their values.
- R8: When `dst_stat_i` is 1, bits 7:5 and every flag the operation does not update take the result value. Each flag the operation does update takes its flag-logic value instead of the result bit.
- R9: Bits 4 and 3 of `status_o` never change because of an operation, whatever the result or destination.
- R10: When `rc_we_i` is 1, bits 4 and 3 take `rc_to_i` and `rc_pd_i` at the next edge. This also happens when an operation executes in the same cycle.
- R11: While `valid_i` and `rc_we_i` are both 0, `status_o` holds its value.
- R12: `result_o` is a combinational function of the current inputs and of the stored carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| valid_i | input | 1 | An operation executes this cycle |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File or immediate operand |
| bit_i | input | 3 | Bit index for the bit clear and bit set operations |
| dst_stat_i | input | 1 | The result is written into the flag register |
| rc_we_i | input | 1 | Reset-cause bit update strobe |
| rc_to_i | input | 1 | New time-out bit value |
| rc_pd_i | input | 1 | New power-down bit value |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Flag register |

## Verification
Random operands and op codes run against a bench model. Between them sit directed pairs that sit on the flag boundaries: 0x0F+0x01 separates digit carry from carry, 0x80+0x80 produces a zero result together with a carry, equal operands in a subtraction show the no-borrow polarity, and 3-4 shows a full borrow. About a quarter of the random operations write the flag register, with f equal to the current flags. These runs separate the protected flag bits from the bits that are written, and an all-ones move into the flag register shows the reset-cause bits holding. Random reset-cause strobes land on the same cycle as operations, which shows that the two write paths do not interfere.

// File: rtl/ulg_alu_pkg.sv
package ulg_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_AND  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_INC  = 4'h6,
    OP_DEC  = 4'h7,
    OP_RLC  = 4'h8,
    OP_RRC  = 4'h9,
    OP_SWAP = 4'hA,
    OP_CLR  = 4'hB,
    OP_BCLR = 4'hC,
    OP_BSET = 4'hD,
    OP_RSV0 = 4'hE,
    OP_RSV1 = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flags_t;

  localparam int STW      = 8;
  localparam int ST_C     = 0;
  localparam int ST_DC    = 1;
  localparam int ST_Z     = 2;
  localparam int ST_PD    = 3;
  localparam int ST_TO    = 4;
  localparam int ST_BANK  = 5;
  localparam logic [STW-1:0] ST_RESET = 8'h18;

endpackage

// File: rtl/ulg_alu_adder.sv
module ulg_alu_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ci_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              half_co_o,
  output logic              co_o
);
  localparam int NIB = DATA_W / 2;

  logic [NIB:0]    low_sum;
  logic [DATA_W:0] full_sum;

  always_comb begin
    low_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, ci_i};
    full_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ci_i};
  end

  assign sum_o     = full_sum[DATA_W-1:0];
  assign half_co_o = low_sum[NIB];
  assign co_o      = full_sum[DATA_W];

endmodule

// File: rtl/ulg_alu_core.sv
module ulg_alu_core
  import ulg_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e                     op_i,
  input  logic [DATA_W-1:0]           w_i,
  input  logic [DATA_W-1:0]           f_i,
  input  logic [$clog2(DATA_W)-1:0]   bit_i,
  input  logic                        cin_i,
  output logic [DATA_W-1:0]           res_o,
  output flags_t                      flg_o,
  output flags_t                      aff_o
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] add_b;
  logic              add_ci;
  logic [DATA_W-1:0] add_sum;
  logic              add_hc;
  logic              add_co;
  logic [DATA_W-1:0] bit_mask;

  // Adder operand steering: subtraction adds the two's complement
  always_comb begin
    add_b  = w_i;
    add_ci = 1'b0;
    unique case (op_i)
      OP_SUB: begin add_b = ~w_i;              add_ci = 1'b1; end
      OP_INC: begin add_b = '0;                add_ci = 1'b1; end
      OP_DEC: begin add_b = {DATA_W{1'b1}};    add_ci = 1'b0; end
      default: begin add_b = w_i;              add_ci = 1'b0; end
    endcase
  end

  ulg_alu_adder #(.DATA_W(DATA_W)) i_adder (
    .a_i       (f_i),
    .b_i       (add_b),
    .ci_i      (add_ci),
    .sum_o     (add_sum),
    .half_co_o (add_hc),
    .co_o      (add_co)
  );

  assign bit_mask = DATA_W'(1) << bit_i;

  always_comb begin
    res_o = f_i;
    flg_o = '{z: 1'b0, dc: add_hc, c: add_co};
    aff_o = '{z: 1'b0, dc: 1'b0, c: 1'b0};
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        res_o = add_sum;
        aff_o = '{z: 1'b1, dc: 1'b1, c: 1'b1};
      end
      OP_INC, OP_DEC: begin
        res_o = add_sum;
        aff_o.z = 1'b1;
      end
      OP_AND: begin res_o = f_i & w_i; aff_o.z = 1'b1; end
      OP_OR:  begin res_o = f_i | w_i; aff_o.z = 1'b1; end
      OP_XOR: begin res_o = f_i ^ w_i; aff_o.z = 1'b1; end
      OP_RLC: begin
        res_o   = {f_i[DATA_W-2:0], cin_i};
        flg_o.c = f_i[DATA_W-1];
        aff_o.c = 1'b1;
      end
      OP_RRC: begin
        res_o   = {cin_i, f_i[DATA_W-1:1]};
        flg_o.c = f_i[0];
        aff_o.c = 1'b1;
      end
      OP_SWAP: res_o = {f_i[NIB-1:0], f_i[DATA_W-1:NIB]};
      OP_CLR: begin res_o = '0; aff_o.z = 1'b1; end
      OP_BCLR: res_o = f_i & ~bit_mask;
      OP_BSET: res_o = f_i | bit_mask;
      default: res_o = f_i;
    endcase
    flg_o.z = (res_o == '0);
  end

endmodule

// File: rtl/ulg_alu_status.sv
module ulg_alu_status
  import ulg_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic           dst_stat_i,
  input  logic [STW-1:0] wdata_i,
  input  flags_t         flg_i,
  input  flags_t         aff_i,
  input  logic           rc_we_i,
  input  logic           rc_to_i,
  input  logic           rc_pd_i,
  output logic [STW-1:0] status_o
);
  logic [STW-1:0] st_q;
  logic [STW-1:0] st_n;
  logic           st_en;

  // Next state: data write first, flag logic overrides, reset-cause bits only via port
  always_comb begin
    st_n = st_q;
    if (valid_i) begin
      if (dst_stat_i) begin
        st_n[STW-1:ST_BANK] = wdata_i[STW-1:ST_BANK];
        st_n[ST_Z:ST_C]     = wdata_i[ST_Z:ST_C];
      end
      if (aff_i.z)  st_n[ST_Z]  = flg_i.z;
      if (aff_i.dc) st_n[ST_DC] = flg_i.dc;
      if (aff_i.c)  st_n[ST_C]  = flg_i.c;
    end
    if (rc_we_i) begin
      st_n[ST_TO] = rc_to_i;
      st_n[ST_PD] = rc_pd_i;
    end
  end

  assign st_en = valid_i | rc_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else if (st_en) st_q <= st_n;
  end

  assign status_o = st_q;

  // R9: reset-cause bits are untouched by any operation
  a_r9_rc_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_we_i |=> status_o[ST_TO:ST_PD] == $past(status_o[ST_TO:ST_PD]));

  // R10: reset-cause port loads both bits
  a_r10_rc_load: assert property (@(posedge clk) disable iff (!rst_n)
    rc_we_i |=> status_o[ST_TO:ST_PD] == {$past(rc_to_i), $past(rc_pd_i)});

  // R11: idle cycles keep the register
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !rc_we_i) |=> $stable(status_o));

  // R8: a flag the operation updates follows flag logic even when the result targets this register
  a_r8_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dst_stat_i && aff_i.z) |=> status_o[ST_Z] == $past(flg_i.z));

endmodule

// File: rtl/ulg_alu_top.sv
module ulg_alu_top
  import ulg_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              dst_stat_i,
  input  logic              rc_we_i,
  input  logic              rc_to_i,
  input  logic              rc_pd_i,
  output logic [DATA_W-1:0] result_o,
  output logic [STW-1:0]    status_o
);
  alu_op_e op;
  flags_t  flg;
  flags_t  aff;

  assign op = alu_op_e'(op_i);

  ulg_alu_core #(.DATA_W(DATA_W)) i_core (
    .op_i  (op),
    .w_i   (w_i),
    .f_i   (f_i),
    .bit_i (bit_i),
    .cin_i (status_o[ST_C]),
    .res_o (result_o),
    .flg_o (flg),
    .aff_o (aff)
  );

  ulg_alu_status i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .dst_stat_i (dst_stat_i),
    .wdata_i    (result_o[STW-1:0]),
    .flg_i      (flg),
    .aff_i      (aff),
    .rc_we_i    (rc_we_i),
    .rc_to_i    (rc_to_i),
    .rc_pd_i    (rc_pd_i),
    .status_o   (status_o)
  );

  // R7: clear sets the zero flag
  a_r7_clr_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'hB) |=> status_o[ST_Z]);

  // R6: moves, swaps and bit operations to a file register keep the three flags
  a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !dst_stat_i &&
     (op_i == 4'h0 || op_i == 4'hA || op_i == 4'hC || op_i == 4'hD || op_i >= 4'hE))
    |=> status_o[ST_Z:ST_C] == $past(status_o[ST_Z:ST_C]));

  // R5: rotate left moves bit 7 of f into carry
  a_r5_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'h8 && !dst_stat_i) |=> status_o[ST_C] == $past(f_i[DATA_W-1]));

endmodule

// File: tb/test_ulg_alu_top.sv
module test_ulg_alu_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid_i;
  logic [3:0] op_i;
  logic [7:0] w_i;
  logic [7:0] f_i;
  logic [2:0] bit_i;
  logic       dst_stat_i;
  logic       rc_we_i;
  logic       rc_to_i;
  logic       rc_pd_i;
  logic [7:0] result_o;
  logic [7:0] status_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] exp_st;

  always #(CLK_P/2) clk = ~clk;

  ulg_alu_top i_ulg_alu_top (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .w_i(w_i), .f_i(f_i),
    .bit_i(bit_i), .dst_stat_i(dst_stat_i), .rc_we_i(rc_we_i), .rc_to_i(rc_to_i),
    .rc_pd_i(rc_pd_i), .result_o(result_o), .status_o(status_o)
  );

  // Returns {affected z,dc,c ; flag z,dc,c ; result}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] f,
                                        input logic [7:0] w, input logic [2:0] b,
                                        input logic cin);
    logic [7:0] r;
    logic z, dc, c;
    logic [2:0] aff;
    r = f; dc = 1'b0; c = 1'b0; aff = 3'b000;
    case (op)
      4'h1: begin r = f + w; c = (int'(f) + int'(w)) > 255;
                  dc = (int'(f % 16) + int'(w % 16)) > 15; aff = 3'b111; end
      4'h2: begin r = f - w; c = (f >= w); dc = (f[3:0] >= w[3:0]); aff = 3'b111; end
      4'h3: begin r = f & w; aff = 3'b100; end
      4'h4: begin r = f | w; aff = 3'b100; end
      4'h5: begin r = f ^ w; aff = 3'b100; end
      4'h6: begin r = f + 8'd1; aff = 3'b100; end
      4'h7: begin r = f - 8'd1; aff = 3'b100; end
      4'h8: begin r = (f << 1) | {7'd0, cin}; c = f[7]; aff = 3'b001; end
      4'h9: begin r = (f >> 1) | {cin, 7'd0}; c = f[0]; aff = 3'b001; end
      4'hA: r = {f[3:0], f[7:4]};
      4'hB: begin r = 8'd0; aff = 3'b100; end
      4'hC: r = f & ~(8'd1 << b);
      4'hD: r = f | (8'd1 << b);
      default: r = f;
    endcase
    z = (r == 8'd0);
    return {aff, z, dc, c, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic dst);
    if (dst) return "R8";
    case (op)
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3, 4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9: return "R5";
      4'hB: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check result, check status after the edge
  task automatic step(input logic v, input logic [3:0] op, input logic [7:0] f,
                      input logic [7:0] w, input logic [2:0] b, input logic dst,
                      input logic rw, input logic rto, input logic rpd);
    logic [13:0] m;
    logic [7:0]  nx;
    @(negedge clk);
    valid_i = v; op_i = op; f_i = f; w_i = w; bit_i = b; dst_stat_i = dst;
    rc_we_i = rw; rc_to_i = rto; rc_pd_i = rpd;
    m  = model(op, f, w, b, exp_st[0]);
    nx = exp_st;
    if (v) begin
      if (dst) begin
        nx[7:5] = m[7:5];
        nx[2:0] = m[2:0];
      end
      if (m[13]) nx[2] = m[10];
      if (m[12]) nx[1] = m[9];
      if (m[11]) nx[0] = m[8];
    end
    if (rw) begin nx[4] = rto; nx[3] = rpd; end
    #1;
    check8("R12", result_o, m[7:0]);
    @(posedge clk); #1;
    exp_st = nx;
    check8(v ? tag_of(op, dst) : (rw ? "R10" : "R11"), status_o, exp_st);
    if (v && !rw) check8("R9", {3'd0, status_o[4:3], 3'd0}, {3'd0, exp_st[4:3], 3'd0});
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; valid_i = 0; op_i = 0; f_i = 0; w_i = 0; bit_i = 0;
    dst_stat_i = 0; rc_we_i = 0; rc_to_i = 0; rc_pd_i = 0;
    exp_st = 8'h18;
    #(CLK_P * 3 + 2);
    check8("R1", status_o, 8'h18);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check8("R1", status_o, 8'h18);

    // Directed corners
    step(1, 4'h1, 8'h0F, 8'h01, 0, 0, 0, 0, 0);      // R2 digit carry only
    step(1, 4'h1, 8'h80, 8'h80, 0, 0, 0, 0, 0);      // R2 zero with carry
    step(1, 4'h2, 8'h05, 8'h05, 0, 0, 0, 0, 0);      // R3 no borrow, zero
    step(1, 4'h2, 8'h03, 8'h04, 0, 0, 0, 0, 0);      // R3 full borrow
    step(1, 4'h3, 8'hF0, 8'h0F, 0, 0, 0, 0, 0);      // R4 and gives zero
    step(1, 4'h6, 8'hFF, 8'h00, 0, 0, 0, 0, 0);      // R4 increment wraps
    step(1, 4'h8, 8'h81, 8'h00, 0, 0, 0, 0, 0);      // R5 rotate left
    step(1, 4'h9, 8'h02, 8'h00, 0, 0, 0, 0, 0);      // R5 rotate right
    step(1, 4'hA, 8'h3C, 8'h00, 0, 0, 0, 0, 0);      // R6 swap
    step(1, 4'hD, 8'h00, 8'h00, 3'd6, 0, 0, 0, 0);   // R6 bit set
    step(1, 4'h0, 8'hFF, 8'h00, 0, 1, 0, 0, 0);      // R8/R9 all-ones move into flags
    step(1, 4'hB, exp_st, 8'h00, 0, 1, 0, 0, 0);     // R7 clear of the flag register
    step(1, 4'h1, exp_st, 8'hFF, 0, 1, 0, 0, 0);     // R8 add into flags
    step(0, 4'h1, 8'h01, 8'h01, 0, 0, 1, 0, 1);      // R10 port write
    step(1, 4'h7, 8'h01, 8'h00, 0, 0, 1, 1, 0);      // R10 with concurrent op
    step(0, 4'h1, 8'hAA, 8'h55, 0, 1, 0, 0, 0);      // R11 idle

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic       dst, rw;
      logic [7:0] f;
      op  = 4'($urandom % 16);
      dst = ($urandom % 4) == 0;
      rw  = ($urandom % 8) == 0;
      f   = dst ? exp_st : 8'($urandom);
      step(($urandom % 8) != 0, op, f, 8'($urandom), 3'($urandom), dst, rw,
           1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule